// File: doc/BRIEF.md
# Video Memory Masked Block-Write Engine

This block holds a small multi-plane frame store of 16 bit planes, organised as rows of column locations. It fills an aligned run of eight columns with the contents of a colour register in a single strobe cycle. A host drives it with active-low row and column strobes, a write-select line, a special-function line, a shared address bus and a 16-bit data bus. All of these are sampled on the system clock, and the block finds the strobe edges from consecutive samples.

The cycle type is fixed at the falling row strobe. At that point the row address is captured and, in per-cycle mask mode, a plane mask is taken from the data bus. At the falling column strobe the address selects a group of eight columns, and the data bus carries a column mask. Each stored bit changes only when both its column and its plane are enabled. The plane mask can also come from a stored mask register. A synchronous load port sets the colour and mask registers, and a combinational debug port reads back any stored word.

Top module: `vram_blockwrite`

## Requirements
- R1: After reset every stored word, the colour register and the mask register are zero, so every debug read returns 16'h0000.
- R2: The row is taken from addr[3:0] as sampled with the first low sample of rowStrobeN. The upper address bits play no part in choosing the row.
- R3: At the first low sample of colStrobeN, addr[5:3] selects columns 8*g to 8*g+7 of the captured row. addr[2:0] is ignored.
- R4: A write happens only if sfSel=0 and wrSelN=0 at the row strobe fall and sfSel=1 at the column strobe fall. Any other combination leaves every stored word unchanged.
- R5: At the column strobe fall, dataIn bit i (i=0..7) enables column 8*g+i for planes 0..7, and dataIn bit 8+i enables the same column for planes 8..15. An enabled bit takes the colour register bit. A disabled bit keeps its value.
- R6: With oldMaskMode=0, the plane mask is dataIn at the row strobe fall. Bit p=1 lets plane p be written, and bit p=0 protects it. A new value is taken in every row cycle.
- R7: With oldMaskMode=1, the plane mask is the stored mask register, and dataIn at the row strobe fall has no effect.
- R8: When loadEn=1 at a rising edge, loadData is stored into the colour register if loadSel=0, or into the mask register if loadSel=1.
- R9: Counting from the first rising edge that samples colStrobeN low, the written words appear on the debug port after the second rising edge and not before it.
- R10: dbgData shows the stored word at row dbgRow and column dbgCol within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobeN | input | 1 | Row strobe, active low |
| colStrobeN | input | 1 | Column strobe, active low |
| wrSelN | input | 1 | Write / write-per-bit select, low for block write |
| sfSel | input | 1 | Special-function select |
| oldMaskMode | input | 1 | 1: plane mask from stored register, 0: from the bus each row cycle |
| addr | input | 6 | Shared row/column address |
| dataIn | input | 16 | Plane mask at row fall, column mask at column fall |
| loadEn | input | 1 | Register load enable |
| loadSel | input | 1 | 0 selects colour register, 1 selects mask register |
| loadData | input | 16 | Register load value |
| dbgRow | input | 4 | Debug read row |
| dbgCol | input | 6 | Debug read column |
| dbgData | output | 16 | Debug read data |

## Verification
The assertions assume that each strobe stays low for more than one clock sample. They also assume that the address, the data bus and the select lines hold their values across the sample in which a strobe falls, so a single edge is seen and it carries one consistent set of values. The stimulus meets this by changing every input only on the falling clock edge. Each strobe and its data are held for at least two samples, and both strobes are released for two samples before the next cycle starts. Debug addresses change only while the block is idle, or while the stored words they point at are stable.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

  // strobes handed from the cycle decoder to the datapath
  typedef struct packed {
    logic captureRow;  // row strobe fell: latch row and bus plane mask
    logic commit;      // block write fires at the next edge
    logic loadColor;   // colour register load
    logic loadMask;    // mask register load
  } bwStrobes_t;

endpackage

// File: rtl/vbw_ctrl.sv
module vbw_ctrl
  import vbw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStrobeN,
  input  logic       colStrobeN,
  input  logic       wrSelN,
  input  logic       sfSel,
  input  logic       loadEn,
  input  logic       loadSel,
  output bwStrobes_t cmd
);

  logic rasQ, rasPrev, casQ, casPrev;
  logic sfQ, wrQ;
  logic blkArmed;
  logic rasFall, casFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ    <= 1'b1;
      rasPrev <= 1'b1;
      casQ    <= 1'b1;
      casPrev <= 1'b1;
      sfQ     <= 1'b0;
      wrQ     <= 1'b1;
    end else begin
      rasQ    <= rowStrobeN;
      rasPrev <= rasQ;
      casQ    <= colStrobeN;
      casPrev <= casQ;
      sfQ     <= sfSel;
      wrQ     <= wrSelN;
    end
  end

  assign rasFall = rasPrev & ~rasQ;
  assign casFall = casPrev & ~casQ;

  // the cycle type is fixed at the row fall and held until the row strobe rises
  always_ff @(posedge clk) begin
    if (!rstN)        blkArmed <= 1'b0;
    else if (rasQ)    blkArmed <= 1'b0;
    else if (rasFall) blkArmed <= ~sfQ & ~wrQ;
  end

  always_comb begin
    cmd.captureRow = rasFall;
    cmd.commit     = casFall & blkArmed & sfQ & ~rasQ;
    cmd.loadColor  = loadEn & ~loadSel;
    cmd.loadMask   = loadEn & loadSel;
  end

  // R4
  no_capture_commit_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.captureRow && cmd.commit));

  // R9
  single_commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> !cmd.commit);

endmodule

// File: rtl/vbw_datapath.sv
module vbw_datapath
  import vbw_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 64,
  parameter int PLANES = 16,
  parameter int GROUP  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bwStrobes_t                 cmd,
  input  logic                       oldMaskMode,
  input  logic [$clog2(COLS)-1:0]    addr,
  input  logic [PLANES-1:0]          dataIn,
  input  logic [PLANES-1:0]          loadData,
  input  logic [$clog2(ROWS)-1:0]    dbgRow,
  input  logic [$clog2(COLS)-1:0]    dbgCol,
  output logic [PLANES-1:0]          dbgData
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int LANE_W = $clog2(GROUP);
  localparam int GRP_W = COL_W - LANE_W;
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = ROWS * COLS;
  localparam int HALF  = PLANES / 2;

  logic [ROW_W-1:0]  rowSample, rowReg;
  logic [GRP_W-1:0]  grpSample;
  logic [PLANES-1:0] dataQ, newMask, colorReg, maskReg, effPlane;
  logic [PLANES-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  laneIdx [GROUP];
  logic [PLANES-1:0] merged [GROUP];
  logic [LANE_W-1:0] unusedAddrLsb;

  assign unusedAddrLsb = addr[LANE_W-1:0];

  // bus samples line up with the strobe samples in the decoder
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowSample <= '0;
      grpSample <= '0;
      dataQ     <= '0;
    end else begin
      rowSample <= addr[ROW_W-1:0];
      grpSample <= addr[COL_W-1:LANE_W];
      dataQ     <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg  <= '0;
      newMask <= '0;
    end else if (cmd.captureRow) begin
      rowReg  <= rowSample;
      newMask <= dataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorReg <= '0;
      maskReg  <= '0;
    end else begin
      if (cmd.loadColor) colorReg <= loadData;
      if (cmd.loadMask)  maskReg  <= loadData;
    end
  end

  assign effPlane = oldMaskMode ? maskReg : newMask;

  for (genvar j = 0; j < GROUP; j++) begin : gLane
    logic [PLANES-1:0] colEn, wrBits, oldWord;
    assign laneIdx[j] = {rowReg, grpSample, LANE_W'(j)};
    assign colEn      = {{HALF{dataQ[HALF+j]}}, {HALF{dataQ[j]}}};
    assign wrBits     = colEn & effPlane;
    assign oldWord    = mem[laneIdx[j]];
    assign merged[j]  = (oldWord & ~wrBits) | (colorReg & wrBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cmd.commit) begin
      for (int j = 0; j < GROUP; j++) mem[laneIdx[j]] <= merged[j];
    end
  end

  assign dbgData = mem[{dbgRow, dbgCol}];

  logic [IDX_W-1:0]  lane0Idx;
  logic [PLANES-1:0] lane0Old;
  assign lane0Idx = laneIdx[0];
  assign lane0Old = mem[lane0Idx];

  // R5
  lane0_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && dataQ[0] && dataQ[HALF] && (&effPlane)) |=>
      (mem[$past(lane0Idx)] == $past(colorReg)));

  // R5
  lane0_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && !dataQ[0] && !dataQ[HALF]) |=>
      (mem[$past(lane0Idx)] == $past(lane0Old)));

  // R6
  plane0_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && !effPlane[0]) |=>
      (mem[$past(lane0Idx)][0] == $past(lane0Old[0])));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cmd.commit) && $stable(dbgRow) && $stable(dbgCol)) |-> $stable(dbgData));

endmodule

// File: rtl/vram_blockwrite.sv
module vram_blockwrite
  import vbw_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 64,
  parameter int PLANES = 16,
  parameter int GROUP  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rowStrobeN,
  input  logic                    colStrobeN,
  input  logic                    wrSelN,
  input  logic                    sfSel,
  input  logic                    oldMaskMode,
  input  logic [$clog2(COLS)-1:0] addr,
  input  logic [PLANES-1:0]       dataIn,
  input  logic                    loadEn,
  input  logic                    loadSel,
  input  logic [PLANES-1:0]       loadData,
  input  logic [$clog2(ROWS)-1:0] dbgRow,
  input  logic [$clog2(COLS)-1:0] dbgCol,
  output logic [PLANES-1:0]       dbgData
);

  bwStrobes_t cmd;

  vbw_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rowStrobeN (rowStrobeN),
    .colStrobeN (colStrobeN),
    .wrSelN     (wrSelN),
    .sfSel      (sfSel),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .cmd        (cmd)
  );

  vbw_datapath #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .PLANES (PLANES),
    .GROUP  (GROUP)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .oldMaskMode (oldMaskMode),
    .addr        (addr),
    .dataIn      (dataIn),
    .loadData    (loadData),
    .dbgRow      (dbgRow),
    .dbgCol      (dbgCol),
    .dbgData     (dbgData)
  );

endmodule

// File: tb/vram_blockwrite_test.sv
`timescale 1ns/1ps
module vram_blockwrite_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rowStrobeN = 1'b1, colStrobeN = 1'b1, wrSelN = 1'b1, sfSel = 1'b0;
  logic        oldMaskMode = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] dataIn = '0;
  logic        loadEn = 1'b0, loadSel = 1'b0;
  logic [15:0] loadData = '0;
  logic [3:0]  dbgRow = '0;
  logic [5:0]  dbgCol = '0;
  logic [15:0] dbgData;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mdl [16][64];
  logic [15:0] mdlColor = '0, mdlMask = '0;

  always #2.5 clk = ~clk;

  vram_blockwrite uut (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .wrSelN(wrSelN), .sfSel(sfSel), .oldMaskMode(oldMaskMode), .addr(addr),
    .dataIn(dataIn), .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .dbgRow(dbgRow), .dbgCol(dbgCol), .dbgData(dbgData)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] mergeWord(input logic [15:0] old, input logic [15:0] color,
                                            input logic [15:0] plane, input logic [15:0] colMask,
                                            input int j);
    logic [15:0] en;
    en = {{8{colMask[8+j]}}, {8{colMask[j]}}} & plane;
    return (old & ~en) | (color & en);
  endfunction

  task automatic checkRow(input string req, input int r);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      dbgRow = 4'(r);
      dbgCol = 6'(c);
      #1;
      check($sformatf("%s row %0d col %0d", req, r, c), dbgData, mdl[r][c]);
    end
  endtask

  task automatic checkAll(input string req);
    for (int r = 0; r < 16; r++) checkRow(req, r);
  endtask

  task automatic loadReg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
    if (sel) mdlMask = val; else mdlColor = val;
  endtask

  // one strobe cycle; also checks the write latency on lane 0 (R9)
  task automatic blockCycle(input string tag, input logic [5:0] rowA, input logic [15:0] rasData,
                            input logic sfRas, input logic wrRas, input logic [5:0] colA,
                            input logic [15:0] casData, input logic sfCas);
    int r, g;
    logic valid;
    logic [15:0] plane, oldW, newW;
    r = int'(rowA[3:0]);
    g = int'(colA[5:3]);
    valid = !sfRas && !wrRas && sfCas;
    plane = oldMaskMode ? mdlMask : rasData;
    @(negedge clk);
    addr = rowA; dataIn = rasData; sfSel = sfRas; wrSelN = wrRas; rowStrobeN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = colA; dataIn = casData; sfSel = sfCas; wrSelN = 1'b0;
    dbgRow = 4'(r); dbgCol = 6'(g * 8);
    oldW = mdl[r][g*8];
    if (valid)
      for (int j = 0; j < 8; j++)
        mdl[r][g*8+j] = mergeWord(mdl[r][g*8+j], mdlColor, plane, casData, j);
    newW = mdl[r][g*8];
    @(negedge clk);
    colStrobeN = 1'b0;
    @(negedge clk);
    check({tag, " R9 before commit"}, dbgData, oldW);
    @(negedge clk);
    check({tag, " R9 after commit"}, dbgData, newW);
    @(negedge clk);
    colStrobeN = 1'b1; rowStrobeN = 1'b1; sfSel = 1'b0; wrSelN = 1'b1; addr = '0; dataIn = '0;
    @(negedge clk);
  endtask

  task automatic testReset();
    // R1 R10: whole store reads zero through the debug port
    checkAll("R1/R10 reset");
  endtask

  task automatic testFullFill();
    // R2 R3 R8: address LSBs 3'b101 ignored, group 1 of row 3 filled
    loadReg(1'b0, 16'hA5C3);
    blockCycle("R3 fill", 6'd3, 16'hFFFF, 1'b0, 1'b0, 6'd13, 16'hFFFF, 1'b1);
    checkRow("R2/R3 fill", 3);
  endtask

  task automatic testColumnMask();
    // R5: lower and upper byte column masks differ
    loadReg(1'b0, 16'h0F3C);
    blockCycle("R5 colmask", 6'd5, 16'hFFFF, 1'b0, 1'b0, 6'd40, 16'h3AC5, 1'b1);
    checkRow("R5 colmask", 5);
  endtask

  task automatic testPlaneMask();
    // R6: only planes 4..7 change over existing data
    loadReg(1'b0, 16'hFFFF);
    blockCycle("R6 plane", 6'd3, 16'h00F0, 1'b0, 1'b0, 6'd8, 16'hFFFF, 1'b1);
    checkRow("R6 plane", 3);
    // R6: the next row cycle takes a new bus mask
    loadReg(1'b0, 16'h1234);
    blockCycle("R6 reenter", 6'd3, 16'h0101, 1'b0, 1'b0, 6'd16, 16'h0FF0, 1'b1);
    checkRow("R6 reenter", 3);
  endtask

  task automatic testOldMask();
    // R7 R8: stored mask used, bus value at row fall ignored; last group
    loadReg(1'b1, 16'hF00F);
    loadReg(1'b0, 16'h5555);
    oldMaskMode = 1'b1;
    blockCycle("R7 oldmask", 6'd9, 16'hFFFF, 1'b0, 1'b0, 6'd63, 16'hFFFF, 1'b1);
    checkRow("R7 oldmask", 9);
    oldMaskMode = 1'b0;
  endtask

  task automatic testDecode();
    // R4: three rejected cycle types leave row 12 unchanged
    loadReg(1'b0, 16'hBEEF);
    blockCycle("R4 sf at row", 6'd12, 16'hFFFF, 1'b1, 1'b0, 6'd0, 16'hFFFF, 1'b1);
    blockCycle("R4 wr at row", 6'd12, 16'hFFFF, 1'b0, 1'b1, 6'd8, 16'hFFFF, 1'b1);
    blockCycle("R4 sf at col", 6'd12, 16'hFFFF, 1'b0, 1'b0, 6'd16, 16'hFFFF, 1'b0);
    checkRow("R4 decode", 12);
    // R2: addr 6'h3F maps to row 15
    blockCycle("R2 row wrap", 6'h3F, 16'hFFFF, 1'b0, 1'b0, 6'd2, 16'h8001, 1'b1);
    checkRow("R2 row wrap", 15);
  endtask

  initial begin
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 64; c++) mdl[r][c] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullFill();
    testColumnMask();
    testPlaneMask();
    testOldMask();
    testDecode();
    checkAll("R10 final");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule